// File: doc/BRIEF.md
# SPI EEPROM Page-Write Slave Controller

This block is a mode-0 SPI slave that sits in front of a small byte-addressed nonvolatile array. It runs entirely on a system clock: chip select, serial clock and serial input are synchronised and their edges are detected internally. It decodes an opcode byte per frame and keeps a write-enable latch. It gathers up to eight data bytes of one page into a local buffer. It then runs a timed write cycle that copies the buffered bytes into the array through a simple address, data and write-strobe port.

A master sets the latch with a one-byte enable frame. It then sends a write frame: opcode, address, data bytes. Raising chip select on a byte boundary starts the write cycle. While the cycle runs, a write-in-progress flag is visible through the status read. Array reads are answered with all-ones, and every other instruction is dropped. The serial output is presented as a data bit plus an output-enable, which the pad turns into a tri-state driver.

Top module: `spi_ee_pagewr`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch (WEL) only if chip select rises when exactly eight bits have been clocked in the frame. Any extra bit in that frame, including a following write instruction, leaves WEL unchanged and performs no write.
- R2: Opcode 0x02 (array write) is ignored unless WEL is set and no write cycle is running.
- R3: Frames use SPI mode 0. SI is sampled on rising SCK, MSB first. A write frame is the opcode, one address byte, then data bytes.
- R4: Buffered data bytes fill the page chosen by address bits 7:3. They start at address bits 2:0 and step up, wrapping from offset 7 to offset 0 of the same page, so later bytes replace earlier ones. Page bytes that were not sent keep their old contents.
- R5: A write cycle starts only if chip select rises after the eighth bit of a data byte, with at least one data byte received. Otherwise the whole write is discarded and the array is not touched.
- R6: After a write cycle starts, WIP stays high for WR_CLKS system clocks. The buffered bytes are in the array when WIP falls, and the array write strobe is never active outside a write cycle.
- R7: WEL clears when the write cycle ends. It falls at no other time.
- R8: Opcode 0x05 returns the status byte on SO, repeated for each further byte: bit 0 = WIP, bit 1 = WEL, bits 7:2 read as zero. Status can be read during a write cycle.
- R9: Opcode 0x03 followed by an address byte returns array bytes from that address. The address increments after each byte and wraps from 0xFF to 0x00.
- R10: During a write cycle, an array read returns 0xFF for every byte, and write-enable and write instructions are ignored.
- R11: so_oe is low whenever chip select is high and outside the data phase of a read or status frame. SO changes only after falling SCK.
- R12: An unknown opcode makes the rest of the frame ignored: no output enable and no change to WEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | SPI serial data in |
| so_d | output | 1 | SPI serial data out value |
| so_oe | output | 1 | Output enable for the SO pad driver |
| arr_addr | output | AW | Array address for reads and commit writes |
| arr_wdata | output | 8 | Array write data |
| arr_we | output | 1 | Array write strobe, one byte per clock |
| arr_rdata | input | 8 | Array read data for arr_addr, combinational |

## Verification
The assertions assume chip select, SCK and SI are slow against the system clock. Each SCK level must last several system clocks, so the two-flop synchronisers never merge two edges. They also assume the array returns read data in the same cycle as the address. The bench keeps SCK at four system clocks per half period, changes SI only while SCK is low, and holds chip select stable around every SCK edge. Its array model answers combinationally and stores a byte on each clock where the write strobe is high.

// File: rtl/spi_ee_pagewr.sv
module spi_ee_pagewr #(
  parameter int AW      = 8,
  parameter int WR_CLKS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  output logic          so_d,
  output logic          so_oe,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_wdata,
  output logic          arr_we,
  input  logic [7:0]    arr_rdata
);
  localparam int TW = $clog2(WR_CLKS);
  localparam logic [7:0] OP_WEN = 8'h06, OP_WR = 8'h02, OP_RD = 8'h03, OP_ST = 8'h05;

  typedef enum logic [2:0] {S_OP, S_WEN, S_WADR, S_WDAT, S_RADR, S_RDAT, S_STAT, S_IGN} st_t;

  logic [2:0] cs_p, sck_p;
  logic [1:0] si_p;
  logic cs_s, cs_d, sck_s, sck_d, si_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p <= '1; sck_p <= '0; si_p <= '0;
    end else begin
      cs_p <= {cs_p[1:0], cs_n}; sck_p <= {sck_p[1:0], sck}; si_p <= {si_p[0], si};
    end
  assign cs_s = cs_p[1];
  assign cs_d = cs_p[2];
  assign sck_s = sck_p[1];
  assign sck_d = sck_p[2];
  assign si_s = si_p[1];

  wire cs_rise = cs_s & ~cs_d;
  wire s_rise = ~cs_s & sck_s & ~sck_d;
  wire s_fall = ~cs_s & ~sck_s & sck_d;

  st_t        st;
  logic [2:0] bitcnt, ptr;
  logic [6:0] sh;
  logic [7:0] osh, raddr;
  logic [AW-4:0] wpage;
  logic [7:0] pbuf [8];
  logic [7:0] mask;
  logic got_data, refuse, wel, wip;
  logic [TW-1:0] timer;

  wire [7:0] sh_in = {sh, si_s};
  wire byte_done = (bitcnt == 3'd7);
  wire [7:0] status = {6'd0, wel, wip};
  wire [7:0] src = (st == S_STAT) ? status : (refuse ? 8'hFF : arr_rdata);
  wire go_write = cs_rise && st == S_WDAT && bitcnt == 3'd0 && got_data;
  wire set_wel = cs_rise && st == S_WEN && bitcnt == 3'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_OP; bitcnt <= '0; sh <= '0; ptr <= '0; wpage <= '0; raddr <= '0;
      mask <= '0; got_data <= 1'b0; refuse <= 1'b0; osh <= '0; so_d <= 1'b0; so_oe <= 1'b0;
    end else if (cs_s) begin
      st <= S_OP; bitcnt <= '0; so_oe <= 1'b0;
    end else begin
      if (s_rise) begin
        bitcnt <= bitcnt + 3'd1;
        sh <= sh_in[6:0];
        case (st)
          S_OP: if (byte_done) begin
            refuse <= wip;
            mask <= wip ? mask : '0;
            got_data <= 1'b0;
            case (sh_in)
              OP_WEN:  st <= wip ? S_IGN : S_WEN;
              OP_WR:   st <= (wel && !wip) ? S_WADR : S_IGN;
              OP_RD:   st <= S_RADR;
              OP_ST:   st <= S_STAT;
              default: st <= S_IGN;
            endcase
          end
          S_WEN: st <= S_IGN;
          S_WADR: if (byte_done) begin
            ptr <= sh_in[2:0]; wpage <= sh_in[AW-1:3]; st <= S_WDAT;
          end
          S_WDAT: if (byte_done) begin
            pbuf[ptr] <= sh_in; mask[ptr] <= 1'b1; ptr <= ptr + 3'd1; got_data <= 1'b1;
          end
          S_RADR: if (byte_done) begin raddr <= sh_in; st <= S_RDAT; end
          S_RDAT: if (byte_done) raddr <= raddr + 8'd1;
          default: ;
        endcase
      end
      if (s_fall && (st == S_STAT || st == S_RDAT)) begin
        so_oe <= 1'b1;
        if (bitcnt == 3'd0) begin so_d <= src[7]; osh <= {src[6:0], 1'b0}; end
        else begin so_d <= osh[7]; osh <= {osh[6:0], 1'b0}; end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wel <= 1'b0; wip <= 1'b0; timer <= '0;
    end else if (wip) begin
      timer <= timer - 1'b1;
      if (timer == '0) begin wip <= 1'b0; wel <= 1'b0; end
    end else if (go_write) begin
      wip <= 1'b1; timer <= TW'(WR_CLKS - 1);
    end else if (set_wel) begin
      wel <= 1'b1;
    end

  assign arr_we = wip && timer < TW'(8) && mask[timer[2:0]];
  assign arr_addr = wip ? {wpage, timer[2:0]} : raddr;
  assign arr_wdata = pbuf[timer[2:0]];

  // R6
  we_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n) arr_we |-> wip);
  // R2
  wip_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n) wip |-> wel);
  // R7
  wel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(wel) |-> $fell(wip));
  // R5
  wip_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(wip) |-> $past(cs_rise));
  // R11
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (cs_s && $past(cs_s)) |-> !so_oe);
  // R11
  so_change_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(so_d) |-> $past(s_fall));
endmodule

// File: tb/sim_spi_ee_pagewr.sv
module sim_spi_ee_pagewr;
  localparam int CLK_NS = 10;
  localparam int WRC = 400;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
  logic so_d, so_oe, arr_we;
  logic [7:0] arr_addr, arr_wdata, arr_rdata;
  logic [7:0] mem [256];
  int total = 0, bad = 0;
  logic oe_seen;

  always #(CLK_NS/2) clk = ~clk;

  spi_ee_pagewr #(.AW(8), .WR_CLKS(WRC)) u0 (
    .clk, .rst_n, .cs_n, .sck, .si, .so_d, .so_oe,
    .arr_addr, .arr_wdata, .arr_we, .arr_rdata);

  assign arr_rdata = mem[arr_addr];
  always @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic fstart(); cs_n = 0; cyc(4); endtask
  task automatic fend(); cyc(2); cs_n = 1; cyc(8); endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 0;
    for (int i = 7; i > 7 - n; i--) begin
      si = tx[i]; cyc(4);
      rx[i] = so_d; if (so_oe) oe_seen = 1;
      sck = 1; cyc(4); sck = 0;
    end
  endtask
  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx); bits(tx, 8, rx); endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] r; fstart(); sbyte(op, r); fend();
  endtask
  task automatic rd_status(output logic [7:0] s);
    logic [7:0] r; fstart(); sbyte(8'h05, r); sbyte(8'h00, s); fend();
  endtask
  task automatic rd_byte(input logic [7:0] a, output logic [7:0] d);
    logic [7:0] r; fstart(); sbyte(8'h03, r); sbyte(a, r); sbyte(8'h00, d); fend();
  endtask
  task automatic wait_done(); cyc(WRC + 20); endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R11 reset oe", so_oe, 0);
    rd_status(s); chk("R8 reset status", s, 8'h00);
  endtask

  task automatic t_wel();
    logic [7:0] s, r;
    op1(8'h06); rd_status(s); chk("R1 wel set", s, 8'h02);
    chk("R11 oe off after frame", so_oe, 0);
    fstart(); sbyte(8'h05, r); sbyte(8'h00, s); sbyte(8'h00, r); fend();
    chk("R8 status repeats", r, 8'h02);
    wait_done();
  endtask

  task automatic t_wel_bad();
    logic [7:0] s, r;
    rst_n = 0; cyc(3); rst_n = 1; cyc(3);
    fstart(); sbyte(8'h06, r); bits(8'h80, 1, r); fend();
    rd_status(s); chk("R1 nine bits", s, 8'h00);
    fstart(); sbyte(8'h06, r); sbyte(8'h02, r); sbyte(8'h30, r); sbyte(8'hC3, r); fend();
    cyc(20); chk("R1 write same frame", mem[8'h30], 8'h30 ^ 8'h5A);
    rd_status(s); chk("R1 wel after same frame", s, 8'h00);
  endtask

  task automatic t_nowel();
    logic [7:0] r, s;
    fstart(); sbyte(8'h02, r); sbyte(8'h31, r); sbyte(8'h77, r); fend();
    wait_done(); chk("R2 write without wel", mem[8'h31], 8'h31 ^ 8'h5A);
    rd_status(s); chk("R2 no wip", s, 8'h00);
  endtask

  task automatic t_byte();
    logic [7:0] r, s;
    op1(8'h06);
    fstart(); sbyte(8'h02, r); sbyte(8'h10, r); sbyte(8'hA5, r); fend();
    rd_status(s); chk("R6 wip during cycle", s, 8'h03);
    chk("R6 not written early", mem[8'h10], 8'h10 ^ 8'h5A);
    wait_done();
    rd_status(s); chk("R7 wel cleared", s, 8'h00);
    rd_byte(8'h10, r); chk("R3 byte write", r, 8'hA5);
  endtask

  task automatic t_wrap();
    logic [7:0] r;
    op1(8'h06);
    fstart(); sbyte(8'h02, r); sbyte(8'h25, r);
    for (int k = 0; k < 10; k++) sbyte(8'hD0 + 8'(k), r);
    fend(); wait_done();
    chk("R4 wrap 25", mem[8'h25], 8'hD8);
    chk("R4 wrap 26", mem[8'h26], 8'hD9);
    chk("R4 wrap 27", mem[8'h27], 8'hD2);
    chk("R4 wrap 20", mem[8'h20], 8'hD3);
    chk("R4 wrap 24", mem[8'h24], 8'hD7);
    chk("R4 next page kept", mem[8'h28], 8'h28 ^ 8'h5A);
    op1(8'h06);
    fstart(); sbyte(8'h02, r); sbyte(8'h52, r); sbyte(8'h11, r); sbyte(8'h22, r); fend(); wait_done();
    chk("R4 partial 53", mem[8'h53], 8'h22);
    chk("R4 partial unsent", mem[8'h54], 8'h54 ^ 8'h5A);
  endtask

  task automatic t_abort();
    logic [7:0] r, s;
    op1(8'h06);
    fstart(); sbyte(8'h02, r); sbyte(8'h40, r); sbyte(8'h99, r); bits(8'hF0, 3, r); fend();
    wait_done(); chk("R5 mid-byte discard", mem[8'h40], 8'h40 ^ 8'h5A);
    rd_status(s); chk("R5 no cycle", s, 8'h02);
    fstart(); sbyte(8'h02, r); sbyte(8'h41, r); fend();
    wait_done(); rd_status(s); chk("R5 no data no cycle", s, 8'h02);
  endtask

  task automatic t_busy();
    logic [7:0] r, s;
    fstart(); sbyte(8'h02, r); sbyte(8'h60, r); sbyte(8'h11, r); fend();
    rd_byte(8'h60, r); chk("R10 refused read", r, 8'hFF);
    fstart(); sbyte(8'h02, r); sbyte(8'h61, r); sbyte(8'h44, r); fend();
    wait_done();
    chk("R10 write ignored busy", mem[8'h61], 8'h61 ^ 8'h5A);
    rd_byte(8'h60, r); chk("R6 committed", r, 8'h11);
  endtask

  task automatic t_seqread();
    logic [7:0] r, a, b, c;
    fstart(); sbyte(8'h03, r); sbyte(8'hFE, r); sbyte(0, a); sbyte(0, b); sbyte(0, c); fend();
    chk("R9 read FE", a, 8'hFE ^ 8'h5A);
    chk("R9 read FF", b, 8'hFF ^ 8'h5A);
    chk("R9 wrap 00", c, 8'h00 ^ 8'h5A);
  endtask

  task automatic t_unknown();
    logic [7:0] r, s;
    oe_seen = 0;
    fstart(); sbyte(8'h9B, r); sbyte(8'h00, r); sbyte(8'h00, r); fend();
    chk("R12 no oe", oe_seen, 0);
    rd_status(s); chk("R12 wel unchanged", s, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    cyc(3); rst_n = 1; cyc(3);
    t_reset();
    t_wel();
    t_wel_bad();
    t_nowel();
    t_byte();
    t_wrap();
    t_abort();
    t_busy();
    t_seqread();
    t_unknown();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule